// File: doc/BRIEF.md
# Background Tile Fetch Pipeline

This block generates the background layer of a tile-based raster display, one 4-bit pixel per dot. The display's dot and line counters drive it. Over each group of eight dots it makes four reads through a synchronous memory port: a tile index, an attribute byte, and two pattern bit-planes. The fetched row of eight pixels goes into a 64-bit shift register that holds sixteen 4-bit entries. That register shifts one entry per active dot, and the output pixel is taken from its upper half at an offset chosen by a 3-bit fine horizontal scroll.

The block also owns the 15-bit scroll address. Its fields are coarse X in bits 4:0, coarse Y in bits 9:5, the nametable select in bits 11:10 and fine Y in bits 14:12. The block steps coarse X after each tile and steps Y at the end of the visible span. It reloads the horizontal fields, and on the pre-render line the vertical fields, from a separately held scroll value `scroll_t`. Palette lookup, sprites, the memory itself and the register write path are outside this block.

Top module: `bg_fetch_pipe`

## Requirements
- R1: Each dot of lines 0..239 and dots 1..256 outputs the tile-register entry at bits [32+4*(7-fine_x) +: 4], read before that dot's shift. The register shifts left by 4 on every fetch dot: dots 1..256 and 321..336 on lines 0..239 and line 261.
- R2: On a fetch dot with dot mod 8 = 1, `mem_rd` is 1 and `mem_addr` = 0x2000 | scroll_v[11:0]. Read data is returned one cycle later. `mem_rd` is 0 on even fetch dots.
- R3: On a fetch dot with dot mod 8 = 3, `mem_addr` = 0x23C0 | (v & 0x0C00) | ((v>>2)&7) | (((v>>7)&7)<<3). The palette pair is the returned byte shifted right by {v[6], v[1], 0} and masked to 2 bits.
- R4: On dot mod 8 = 5, `mem_addr` = (pat_hi ? 0x1000 : 0) + tile_index*16 + v[14:12]. On dot mod 8 = 7 it is that value + 8.
- R5: On dots with dot mod 8 = 0, after the shift, eight entries {palette[1:0], high_bit, low_bit} are ORed into the low 32 bits, with pattern bit 7 in the most significant entry.
- R6: On those load dots other than dot 256, coarse X increments. At 31 it wraps to 0 and toggles bit 10.
- R7: On dot 256, fine Y increments. When fine Y is 7 it wraps to 0 and coarse Y increments. Coarse Y 29 wraps to 0 and toggles bit 11; coarse Y 31 wraps to 0 without a toggle.
- R8: On dot 257 of lines 0..239 and 261, scroll_v bits 10 and 4:0 are copied from `scroll_t`.
- R9: On line 261, dots 280..304, scroll_v bits 14:11 and 9:5 are copied from `scroll_t`.
- R10: `pixel` is 0 when `bg_show` is 0, and on dots 1..8 when `bg_left` is 0.
- R11: On lines 240..260, and outside the fetch and copy dots, `mem_rd` stays 0 and scroll_v holds. `pixel` is 0 outside lines 0..239 and dots 1..256.
- R12: While `rst_n` is low, scroll_v is 0, `mem_rd` is 0 and `pixel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, one dot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| dot | input | 9 | Current dot within the line, 0..340 |
| line | input | 9 | Current line, 0..261 |
| scroll_t | input | 15 | Held scroll value used for reloads |
| fine_x | input | 3 | Fine horizontal scroll |
| pat_hi | input | 1 | Selects pattern table at 0x1000 |
| bg_show | input | 1 | Background display enable |
| bg_left | input | 1 | Background enable for dots 1..8 |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | 14 | Read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |
| pixel | output | 4 | Background pixel {palette, high, low} |
| scroll_v | output | 15 | Current scroll address |

## Verification
The bench goes after the coarse-X wrap at 31. A design that forgets the nametable toggle there fetches the wrong tile row for the rest of the line. It goes after coarse Y of 29 and of 31: a design that treats them alike either skips the vertical nametable switch or switches twice. Fine-X values across the whole range are used. An off-by-one in the entry select would shift every pixel by one dot, and a late capture of the high plane would load stale bits. The bench also masks the left column and the whole layer, checks that idle lines leave the scroll address untouched, and checks that the dot-257 and pre-render copies write only their own fields.

// File: rtl/bg_fetch_pipe.sv
module bg_fetch_pipe #(
  parameter int DOT_W        = 9,
  parameter int LINE_W       = 9,
  parameter int ADDR_W       = 14,
  parameter int VIS_DOTS     = 256,
  parameter int VIS_LINES    = 240,
  parameter int PRE_LINE     = 261,
  parameter int PRE_FIRST    = 321,
  parameter int PRE_LAST     = 336,
  parameter int COPY_X_DOT   = 257,
  parameter int COPY_Y_FIRST = 280,
  parameter int COPY_Y_LAST  = 304,
  parameter int LEFT_DOTS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic [14:0]       scroll_t,
  input  logic [2:0]        fine_x,
  input  logic              pat_hi,
  input  logic              bg_show,
  input  logic              bg_left,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [3:0]        pixel,
  output logic [14:0]       scroll_v
);

  localparam logic [DOT_W-1:0]  D_VIS   = DOT_W'(VIS_DOTS);
  localparam logic [DOT_W-1:0]  D_PF0   = DOT_W'(PRE_FIRST);
  localparam logic [DOT_W-1:0]  D_PF1   = DOT_W'(PRE_LAST);
  localparam logic [DOT_W-1:0]  D_CX    = DOT_W'(COPY_X_DOT);
  localparam logic [DOT_W-1:0]  D_CY0   = DOT_W'(COPY_Y_FIRST);
  localparam logic [DOT_W-1:0]  D_CY1   = DOT_W'(COPY_Y_LAST);
  localparam logic [DOT_W-1:0]  D_LEFT  = DOT_W'(LEFT_DOTS);
  localparam logic [DOT_W-1:0]  D_ONE   = DOT_W'(1);
  localparam logic [LINE_W-1:0] L_VIS   = LINE_W'(VIS_LINES);
  localparam logic [LINE_W-1:0] L_PRE   = LINE_W'(PRE_LINE);
  localparam int                PX      = 8;

  logic [14:0] v_q, v_nxt, x_inc, y_inc;
  logic [63:0] tile_q;
  logic [31:0] load_row, tile_hi;
  logic [7:0]  name_q, lo_q;
  logic [1:0]  pal_q;
  logic [2:0]  phase;
  logic [13:0] addr14;
  logic        render_line, fetch_dot, fetch_win, vis_px, left_px;

  assign phase       = dot[2:0];
  assign render_line = (line < L_VIS) || (line == L_PRE);
  assign fetch_dot   = (dot >= D_ONE && dot <= D_VIS) || (dot >= D_PF0 && dot <= D_PF1);
  assign fetch_win   = render_line && fetch_dot;
  assign mem_rd      = rst_n && fetch_win && phase[0];
  assign scroll_v    = v_q;

  always_comb begin
    case (phase)
      3'd1:    addr14 = {2'b10, v_q[11:0]};
      3'd3:    addr14 = {2'b10, v_q[11:10], 4'b1111, v_q[9:7], v_q[4:2]};
      3'd5:    addr14 = {1'b0, pat_hi, name_q, 1'b0, v_q[14:12]};
      3'd7:    addr14 = {1'b0, pat_hi, name_q, 1'b1, v_q[14:12]};
      default: addr14 = '0;
    endcase
  end
  assign mem_addr = ADDR_W'(addr14);

  for (genvar k = 0; k < PX; k++) begin : g_row
    assign load_row[4*k +: 4] = {pal_q, mem_rdata[k], lo_q[k]};
  end

  always_comb begin
    x_inc = v_q;
    if (v_q[4:0] == 5'd31) begin
      x_inc[4:0] = 5'd0;
      x_inc[10]  = ~v_q[10];
    end else begin
      x_inc[4:0] = v_q[4:0] + 5'd1;
    end
  end

  always_comb begin
    y_inc = v_q;
    if (v_q[14:12] != 3'd7) begin
      y_inc[14:12] = v_q[14:12] + 3'd1;
    end else begin
      y_inc[14:12] = 3'd0;
      if (v_q[9:5] == 5'd29) begin
        y_inc[9:5] = 5'd0;
        y_inc[11]  = ~v_q[11];
      end else if (v_q[9:5] == 5'd31) begin
        y_inc[9:5] = 5'd0;
      end else begin
        y_inc[9:5] = v_q[9:5] + 5'd1;
      end
    end
  end

  always_comb begin
    v_nxt = v_q;
    if (fetch_win && phase == 3'd0) begin
      v_nxt = (dot == D_VIS) ? y_inc : x_inc;
    end else if (render_line && dot == D_CX) begin
      v_nxt[10]  = scroll_t[10];
      v_nxt[4:0] = scroll_t[4:0];
    end else if (line == L_PRE && dot >= D_CY0 && dot <= D_CY1) begin
      v_nxt[14:11] = scroll_t[14:11];
      v_nxt[9:5]   = scroll_t[9:5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= '0;
      tile_q <= '0;
      name_q <= '0;
      lo_q   <= '0;
      pal_q  <= '0;
    end else begin
      v_q <= v_nxt;
      if (fetch_win) begin
        tile_q <= {tile_q[59:0], 4'h0} | ((phase == 3'd0) ? {32'h0, load_row} : 64'h0);
        case (phase)
          3'd2: name_q <= mem_rdata;
          3'd4: pal_q  <= 2'(mem_rdata >> {v_q[6], v_q[1], 1'b0});
          3'd6: lo_q   <= mem_rdata;
          default: ;
        endcase
      end
    end
  end

  assign tile_hi = tile_q[63:32];
  assign vis_px  = (line < L_VIS) && dot >= D_ONE && dot <= D_VIS;
  assign left_px = dot >= D_ONE && dot <= D_LEFT;
  assign pixel   = (rst_n && vis_px && bg_show && !(left_px && !bg_left))
                   ? tile_hi[{~fine_x, 2'b00} +: 4] : 4'h0;

  // R6
  a_r6_coarse_x_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_win && phase == 3'd0 && dot != D_VIS && scroll_v[4:0] != 5'd31)
    |=> (scroll_v[4:0] == $past(scroll_v[4:0]) + 5'd1));

  // R6
  a_r6_coarse_x_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_win && phase == 3'd0 && dot != D_VIS && scroll_v[4:0] == 5'd31)
    |=> (scroll_v[4:0] == 5'd0 && scroll_v[10] != $past(scroll_v[10])));

  // R7
  a_r7_coarse_y_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_win && dot == D_VIS && scroll_v[14:12] == 3'd7 && scroll_v[9:5] == 5'd29)
    |=> (scroll_v[9:5] == 5'd0 && scroll_v[11] != $past(scroll_v[11])));

  // R11
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!render_line) |=> $stable(scroll_v));

endmodule

// File: tb/bg_fetch_pipe_tb_top.sv
module bg_fetch_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {scroll_t[14:0], fine_x[2:0], pat_hi, bg_show, bg_left}
  localparam logic [20:0] VEC [NVEC] = '{
    {3'd0, 2'b00, 5'd0,  5'd0,  3'd0, 1'b0, 1'b1, 1'b1},
    {3'd3, 2'b01, 5'd5,  5'd10, 3'd5, 1'b1, 1'b1, 1'b0},
    {3'd7, 2'b10, 5'd29, 5'd28, 3'd3, 1'b0, 1'b1, 1'b1},
    {3'd7, 2'b11, 5'd31, 5'd0,  3'd7, 1'b1, 1'b1, 1'b1},
    {3'd1, 2'b00, 5'd12, 5'd3,  3'd2, 1'b0, 1'b0, 1'b1},
    {3'd6, 2'b01, 5'd2,  5'd17, 3'd1, 1'b1, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  dot = '0;
  logic [8:0]  line = '0;
  logic [14:0] scroll_t = '0;
  logic [2:0]  fine_x = '0;
  logic        pat_hi = 1'b0, bg_show = 1'b1, bg_left = 1'b1;
  logic        mem_rd;
  logic [13:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [3:0]  pixel;
  logic [14:0] scroll_v;

  int n_checks = 0;
  int n_errors = 0;

  logic [15:0] mv = '0;
  logic [63:0] mtile = '0;
  logic [7:0]  mname = '0, mlo = '0, mhi = '0;
  logic [1:0]  mpal = '0;

  bg_fetch_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .dot(dot), .line(line), .scroll_t(scroll_t),
    .fine_x(fine_x), .pat_hi(pat_hi), .bg_show(bg_show), .bg_left(bg_left),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pixel(pixel), .scroll_v(scroll_v)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd13) ^ {a[13:8], a[1:0]} ^ 8'h5A;
  endfunction

  always @(posedge clk) mem_rdata <= memf({2'b00, mem_addr});

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s line=%0d dot=%0d actual=%0h expected=%0h", tag, line, dot, act, exp);
    end
  endtask

  function automatic bit in_win(input int ln, input int dt);
    return (ln < 240 || ln == 261) && ((dt >= 1 && dt <= 256) || (dt >= 321 && dt <= 336));
  endfunction

  function automatic logic [15:0] attr_addr(input logic [15:0] v);
    return 16'h23C0 | (v & 16'h0C00) | ((v >> 2) & 16'h7) | (((v >> 7) & 16'h7) << 3);
  endfunction

  function automatic logic [15:0] pat_addr(input logic [15:0] v);
    return (pat_hi ? 16'h1000 : 16'h0) + {8'h0, mname} * 16'd16 + ((v >> 12) & 16'h7);
  endfunction

  task automatic model_step(input int ln, input int dt);
    int fy, cy;
    logic [31:0] row;
    if (in_win(ln, dt)) begin
      mtile = mtile << 4;
      case (dt % 8)
        1: mname = memf(16'h2000 | (mv & 16'h0FFF));
        3: mpal = 2'((memf(attr_addr(mv)) >> ((mv & 16'h2) | ((mv & 16'h40) >> 4))) & 8'h3);
        5: mlo = memf(pat_addr(mv));
        7: mhi = memf(pat_addr(mv) + 16'd8);
        0: begin
          row = '0;
          for (int i = 7; i >= 0; i--) row = (row << 4) | {28'h0, mpal, mhi[i], mlo[i]};
          mtile = mtile | {32'h0, row};
          if (dt == 256) begin
            fy = int'(mv[14:12]); cy = int'(mv[9:5]);
            if (fy < 7) fy++;
            else begin
              fy = 0;
              if (cy == 29) begin cy = 0; mv[11] = ~mv[11]; end
              else if (cy == 31) cy = 0;
              else cy++;
            end
            mv[14:12] = 3'(fy); mv[9:5] = 5'(cy);
          end else begin
            if (mv[4:0] == 5'd31) begin mv[4:0] = 0; mv[10] = ~mv[10]; end
            else mv[4:0] = mv[4:0] + 5'd1;
          end
        end
        default: ;
      endcase
    end
    if ((ln < 240 || ln == 261) && dt == 257) begin
      mv[10] = scroll_t[10]; mv[4:0] = scroll_t[4:0];
    end
    if (ln == 261 && dt >= 280 && dt <= 304) begin
      mv[14:11] = scroll_t[14:11]; mv[9:5] = scroll_t[9:5];
    end
  endtask

  task automatic step(input int ln, input int dt);
    logic [3:0] ep;
    string ptag, vtag;
    bit masked;
    @(negedge clk);
    line = 9'(ln); dot = 9'(dt);
    #1;
    masked = !bg_show || (dt >= 1 && dt <= 8 && !bg_left);
    ep = 4'h0;
    if (ln < 240 && dt >= 1 && dt <= 256 && !masked)
      ep = 4'((mtile >> 32 >> ((7 - int'(fine_x)) * 4)) & 64'hF);
    ptag = masked ? "R10" : ((ln < 240 && dt >= 1 && dt <= 256) ? "R1 R5" : "R11");
    chk(ptag, {28'h0, pixel}, {28'h0, ep});
    if (in_win(ln, dt) && dt % 2 == 1) begin
      chk("R2 rd", {31'h0, mem_rd}, 32'h1);
      case (dt % 8)
        1: chk("R2", {18'h0, mem_addr}, {16'h0, 16'h2000 | (mv & 16'h0FFF)});
        3: chk("R3", {18'h0, mem_addr}, {16'h0, attr_addr(mv)});
        5: chk("R4", {18'h0, mem_addr}, {16'h0, pat_addr(mv)});
        default: chk("R4", {18'h0, mem_addr}, {16'h0, pat_addr(mv) + 16'd8});
      endcase
    end else begin
      chk(in_win(ln, dt) ? "R2 even" : "R11", {31'h0, mem_rd}, 32'h0);
    end
    @(posedge clk);
    model_step(ln, dt);
    if (in_win(ln, dt) && dt == 256) vtag = "R7";
    else if (in_win(ln, dt) && dt % 8 == 0) vtag = "R6";
    else if (dt == 257 && (ln < 240 || ln == 261)) vtag = "R8";
    else if (ln == 261 && dt >= 280 && dt <= 304) vtag = "R9";
    else vtag = "R11";
    #1;
    chk(vtag, {17'h0, scroll_v}, {17'h0, mv[14:0]});
  endtask

  task automatic run_line(input int ln);
    for (int d = 0; d <= 340; d++) step(ln, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    line = 9'd0; dot = 9'd3; bg_show = 1'b1; bg_left = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 v", {17'h0, scroll_v}, 32'h0);
    chk("R12 rd", {31'h0, mem_rd}, 32'h0);
    chk("R12 pixel", {28'h0, pixel}, 32'h0);
    line = 9'd245; dot = 9'd0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      scroll_t = VEC[i][20:6];
      fine_x   = VEC[i][5:3];
      pat_hi   = VEC[i][2];
      bg_show  = VEC[i][1];
      bg_left  = VEC[i][0];
      run_line(261);
      run_line(0);
      run_line(1);
    end

    // R11: an idle line between frames must leave the scroll address alone
    bg_show = 1'b1; bg_left = 1'b1;
    run_line(245);
    run_line(261);
    run_line(0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule